// File: doc/BRIEF.md
# Pipelined Converter Digital Correction

This block sits behind the analog stages of a twelve-stage pipelined converter. Every stage resolves its residue with a pair of comparators, so it hands over a 2-bit decision whose extra range is redundancy. Because a sample moves forward one stage per half clock cycle, the decisions for one sample reach the block on twelve different clock edges. Even-numbered stages report on falling edges and odd-numbered stages on rising edges.

The block retimes each decision onto the rising edge and delays it in a per-stage line. All twelve decisions of one sample therefore meet in one cycle. They are combined by overlap-add with a binary weight per stage, clamped to the output range and registered as a 12-bit offset-binary word. The output register freezes while the power-down input is high. A per-bit drive enable lets the pad ring release the data bus.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While reset is high, and after it falls until the first aligned sample emerges, data_out reads 0x800.
- R2: Stage k (0 is the most significant) is sampled for the sample taken at rising edge E at a fixed edge. For even k this is the falling edge at E + k/2 + 0.5 cycles; for odd k it is the rising edge at E + (k+1)/2. The corrected word appears on data_out right after rising edge E + 7.
- R3: A stage code is 2 bits in stage_codes[2k+1:2k] with values 0, 1 or 2. The output is 2048 + sum over k of (code_k - 1) * 2^(11-k).
- R4: Code 3 is treated exactly as code 2.
- R5: A sum above 4095 is clamped to 0xFFF.
- R6: A sum below 0 is clamped to 0x000.
- R7: Different code sets with equal weighted sums give the same word. For example, stage 0 at 2 with stage 1 at 0 gives the same word as stage 0 at 1 with stage 1 at 2.
- R8: With out_en_n high, all bits of data_oe are 0; with it low, all are 1. The input has no effect on the value in the output register.
- R9: While pwr_down is high at a rising edge, data_out keeps its value. After pwr_down falls, the next rising edge loads the current corrected word.
- R10: A new word is produced every cycle for back-to-back samples, and data_out never carries unknown bits after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stage_codes | input | 12x2 | Raw 2-bit decision of each stage, stage k in bits [2k+1:2k] |
| out_en_n | input | 1 | High releases the data bus |
| pwr_down | input | 1 | High freezes the output register |
| data_out | output | 12 | Corrected offset-binary word |
| data_oe | output | 12 | Per-bit drive enable for data_out |

## Verification
On every cycle, the assertions check four things: the mid-scale value following reset, the frozen output while powered down, the all-or-none drive enable, and known output bits. The bench's scenarios are the only way to show the arithmetic. These cover the stage weighting, the illegal-code mapping, clamping at both rails and the equivalence of redundant code sets. They also cover the exact half-cycle capture points and seven-cycle latency, which a scoreboard confirms against a stream of staggered decisions.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    typedef enum logic [1:0] {
        CODE_LO  = 2'd0,
        CODE_MID = 2'd1,
        CODE_HI  = 2'd2,
        CODE_BAD = 2'd3
    } stage_code_e;

    // An illegal decision is folded onto the high code.
    function automatic logic [1:0] fold_code(input logic [1:0] raw);
        return (raw == CODE_BAD) ? CODE_HI : raw;
    endfunction

    // Rising-edge delay stages needed by stage k so that all stages align.
    function automatic int align_depth(input int nstage, input int k);
        return nstage / 2 - k / 2;
    endfunction

endpackage

// File: rtl/stage_align.sv
module stage_align
    import adc_corr_pkg::*;
#(
    parameter int NSTAGE = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSTAGE-1:0][1:0] raw,
    output logic [NSTAGE-1:0][1:0] aligned
);

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        localparam int DEPTH = align_depth(NSTAGE, k);
        logic [1:0] entry;
        logic [1:0] line [DEPTH];

        if (k % 2 == 0) begin : g_fall
            logic [1:0] fall_q;
            always_ff @(negedge clk) begin
                if (rst) fall_q <= CODE_MID;
                else     fall_q <= fold_code(raw[k]);
            end
            assign entry = fall_q;
        end else begin : g_rise
            assign entry = fold_code(raw[k]);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int j = 0; j < DEPTH; j++) line[j] <= CODE_MID;
            end else begin
                line[0] <= entry;
                for (int j = 1; j < DEPTH; j++) line[j] <= line[j-1];
            end
        end

        assign aligned[k] = line[DEPTH-1];
    end

endmodule

// File: rtl/overlap_sum.sv
module overlap_sum
    import adc_corr_pkg::*;
#(
    parameter int NSTAGE = 12
) (
    input  logic [NSTAGE-1:0][1:0] aligned,
    output logic [NSTAGE-1:0]      word
);

    localparam int AW = NSTAGE + 3;
    localparam logic signed [AW-1:0] MIDV = AW'(1) <<< (NSTAGE - 1);
    localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< NSTAGE) - AW'(1);

    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] step;

    always_comb begin
        acc  = MIDV;
        step = '0;
        for (int k = 0; k < NSTAGE; k++) begin
            step = AW'(1) <<< (NSTAGE - 1 - k);
            case (aligned[k])
                CODE_LO: acc = acc - step;
                CODE_HI: acc = acc + step;
                default: acc = acc;
            endcase
        end
        if (acc < 0)         word = '0;
        else if (acc > MAXV) word = '1;
        else                 word = acc[NSTAGE-1:0];
    end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pwr_down,
    input  logic         out_en_n,
    input  logic [W-1:0] word,
    output logic [W-1:0] data_out,
    output logic [W-1:0] data_oe
);

    localparam logic [W-1:0] MIDW = W'(1) << (W - 1);

    always_ff @(posedge clk) begin
        if (rst)            data_out <= MIDW;
        else if (!pwr_down) data_out <= word;
    end

    assign data_oe = {W{~out_en_n}};

endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
    parameter int NSTAGE = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSTAGE-1:0][1:0] stage_codes,
    input  logic                   out_en_n,
    input  logic                   pwr_down,
    output logic [NSTAGE-1:0]      data_out,
    output logic [NSTAGE-1:0]      data_oe
);

    logic [NSTAGE-1:0][1:0] aligned;
    logic [NSTAGE-1:0]      word;

    stage_align #(.NSTAGE(NSTAGE)) u_align (
        .clk     (clk),
        .rst     (rst),
        .raw     (stage_codes),
        .aligned (aligned)
    );

    overlap_sum #(.NSTAGE(NSTAGE)) u_sum (
        .aligned (aligned),
        .word    (word)
    );

    out_stage #(.W(NSTAGE)) u_out (
        .clk      (clk),
        .rst      (rst),
        .pwr_down (pwr_down),
        .out_en_n (out_en_n),
        .word     (word),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

endmodule

// File: rtl/adc_corr_checker.sv
module adc_corr_checker #(
    parameter int NSTAGE = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_down,
    input logic [NSTAGE-1:0] data_out,
    input logic [NSTAGE-1:0] data_oe
);

    localparam logic [NSTAGE-1:0] MIDW = NSTAGE'(1) << (NSTAGE - 1);

    a_r1_reset_mid: assert property (@(posedge clk)
        rst |=> data_out == MIDW);

    a_r9_pd_hold: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> $stable(data_out));

    a_r8_oe_all_or_none: assert property (@(posedge clk) disable iff (rst)
        (data_oe == '0) || (data_oe == '1));

    a_r10_known_out: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(data_out));

endmodule

bind pipe_adc_corrector adc_corr_checker #(.NSTAGE(NSTAGE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_down (pwr_down),
    .data_out (data_out),
    .data_oe  (data_oe)
);

// File: tb/tb_pipe_adc_corrector.sv
`timescale 1ns/1ps
module tb_pipe_adc_corrector;

    localparam int NS  = 48;
    localparam int LAT = 7;

    logic             clk = 1'b0;
    logic             rst;
    logic [11:0][1:0] stage_codes;
    logic             out_en_n;
    logic             pwr_down;
    logic [11:0]      data_out;
    logic [11:0]      data_oe;

    int checks   = 0;
    int failures = 0;
    logic [23:0] stream [NS];
    int expq [$];

    pipe_adc_corrector dut (
        .clk         (clk),
        .rst         (rst),
        .stage_codes (stage_codes),
        .out_en_n    (out_en_n),
        .pwr_down    (pwr_down),
        .data_out    (data_out),
        .data_oe     (data_oe)
    );

    always #4 clk = ~clk;

    function automatic int exp_of(input logic [23:0] c);
        int acc = 2048;
        for (int k = 0; k < 12; k++) begin
            int v = int'(c[2*k +: 2]);
            if (v == 3) v = 2;
            acc += (v - 1) * (1 << (11 - k));
        end
        if (acc < 0) acc = 0;
        if (acc > 4095) acc = 4095;
        return acc;
    endfunction

    function automatic logic [23:0] with_code(input logic [23:0] base, input int k,
                                              input logic [1:0] v);
        logic [23:0] r = base;
        r[2*k +: 2] = v;
        return r;
    endfunction

    function automatic logic [1:0] code_of(input int s, input int k);
        if (s < 0 || s >= NS) return 2'd1;
        return stream[s][2*k +: 2];
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R3";
            1: return "R5";
            2: return "R6";
            3, 4: return "R7";
            5, 6: return "R4";
            7: return "R2";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
        end
    endtask

    task automatic drive_all(input logic [23:0] c);
        for (int k = 0; k < 12; k++) stage_codes[k] = c[2*k +: 2];
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [23:0] mid_all = 24'h555555;
        logic [23:0] pat_a;
        int a_val;
        logic [31:0] x = 32'h1234_5678;

        stream[0] = mid_all;
        stream[1] = 24'hAAAAAA;
        stream[2] = 24'h000000;
        stream[3] = with_code(with_code(mid_all, 0, 2'd2), 1, 2'd0);
        stream[4] = with_code(mid_all, 1, 2'd2);
        stream[5] = 24'hFFFFFF;
        stream[6] = with_code(mid_all, 5, 2'd3);
        stream[7] = with_code(mid_all, 11, 2'd0);
        for (int s = 8; s < NS; s++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            stream[s] = x[23:0];
        end

        rst = 1'b1; out_en_n = 1'b0; pwr_down = 1'b0;
        drive_all(mid_all);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R1", int'(data_out), 12'h800);
        check("R8", int'(data_oe), 12'hFFF);
        rst = 1'b0;

        for (int e = 0; e < NS + LAT + 1; e++) begin
            @(posedge clk); #1;
            if (e < NS) expq.push_back(exp_of(stream[e]));
            for (int k = 0; k < 12; k += 2) stage_codes[k] = code_of(e - k / 2, k);
            @(negedge clk); #1;
            if (e < LAT) begin
                check("R1", int'(data_out), 12'h800);
            end else if (e - LAT < NS) begin
                check(tag_of(e - LAT), int'(data_out), expq.pop_front());
            end
            for (int k = 1; k < 12; k += 2) stage_codes[k] = code_of(e + 1 - (k + 1) / 2, k);
        end

        pat_a = with_code(with_code(with_code(mid_all, 0, 2'd2), 1, 2'd0), 2, 2'd2);
        a_val = exp_of(pat_a);
        drive_all(pat_a);
        repeat (9) @(posedge clk);
        @(negedge clk); #1;
        check("R3", int'(data_out), a_val);
        pwr_down = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            drive_all(24'h000000);
            @(negedge clk); #1;
            check("R9", int'(data_out), a_val);
            if (i == 3) begin
                out_en_n = 1'b1; #1;
                check("R8", int'(data_oe), 0);
            end
            if (i == 5) begin
                out_en_n = 1'b0; #1;
                check("R8", int'(data_oe), 12'hFFF);
                check("R8", int'(data_out), a_val);
            end
        end
        pwr_down = 1'b0;
        @(posedge clk);
        @(negedge clk); #1;
        check("R9", int'(data_out), 0);
        check("R6", int'(data_out), exp_of(24'h000000));

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule